// File: doc/BRIEF.md
# Latched Second-Level Interrupt Controller

This block gathers interrupt events from a set of sources (32 by default, one bit per source in every register) and presents one summary interrupt to a parent controller. Each source passes through a synchroniser. Its synchronised value then feeds a status register. Each source also has a mask bit. A source with mask bit 1 is disabled. Software never has to read, modify and write the mask. It writes ones to a mask-set word to disable sources, and ones to a mask-clear word to enable them.

A build-time parameter selects one of two variants. In the latched variant, a rising edge of a source sets its status bit. The bit stays set until software writes a one to it through an acknowledge word. In the level variant, status follows the synchronised inputs and there is no acknowledge word. The mask words in this variant move down by two word positions. In both variants the summary output is a register. It is high one cycle after any status bit is set whose mask bit is 0.

Register access uses a plain single-cycle bus with a word address and a data path one source wide. These are control and status pins, so there is no valid/ready handshake. A write takes effect at the clock edge where `bus_sel` and `bus_wr` are both high. Read data is combinational while `bus_sel` is high and `bus_wr` is low, and is 0 at all other times.

Top module: `l2irq_ctrl`

## Requirements
- R1: After reset every mask bit reads 1, every status bit reads 0 and `irq_out` is 0.
- R2: In the latched variant (`LATCHED`=1), a rising edge of a source sets its status bit once the edge has passed `SYNC_STAGES` synchroniser flops. A later falling edge leaves the bit set.
- R3: In the latched variant, writing word address 2 (byte offset 0x08) clears each status bit written as 1. Bits written as 0 keep their value.
- R4: Writing ones to the mask-set word sets those mask bits, and writing ones to the mask-clear word clears them. Zero bits leave their mask bits unchanged.
  - Latched variant: status is at word 0, mask read-back at word 3, mask-set at word 4 and mask-clear at word 5.
  - Level variant: status is at word 0, mask read-back at word 1, mask-set at word 2 and mask-clear at word 3.
- R5: `irq_out` is 1 in the cycle after (status AND NOT mask) is nonzero, and 0 in the cycle after it is zero.
- R6: Setting a mask bit leaves its status bit unchanged. A pending latched event drives `irq_out` again once the source is unmasked.
- R7: In the latched variant, suppose an acknowledge of a bit and a new rising edge on the same source reach the status register at the same clock edge. The status bit then ends set.
- R8: In the level variant, each status bit equals its synchronised input every cycle. It drops when the input drops, with no acknowledge.
- R9: Reads of word addresses outside the readable map return 0; the write-only mask-set, mask-clear and acknowledge words count as outside it. Writes to word addresses that are not mapped change neither mask nor status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | Raw interrupt sources, asynchronous to clk |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | NUM_SRC | Write data, one bit per source |
| bus_rdata | output | NUM_SRC | Combinational read data |
| irq_out | output | 1 | Registered summary interrupt to the parent |

## Verification
The assertions assume that `bus_sel`, `bus_wr`, `bus_addr` and `bus_wdata` are held low or stable around each rising clock edge. They also assume that a single access carries exactly one address, so mask-set and mask-clear never meet in the same cycle. The bench changes every bus input and source only at falling edges and returns `bus_sel` to 0 between accesses. It also drives sources as clean steps held for several cycles, so every edge reaches the capture stage exactly once.

// File: rtl/l2irq_pkg.sv
package l2irq_pkg;

  localparam int WORD_AW = 3;

  typedef struct packed {
    logic [WORD_AW-1:0] status;
    logic [WORD_AW-1:0] ack;
    logic [WORD_AW-1:0] mask;
    logic [WORD_AW-1:0] mset;
    logic [WORD_AW-1:0] mclr;
    logic               has_ack;
  } reg_map_t;

  // Word-address layout per variant; the level map drops the acknowledge
  // word and moves the three mask words down by two positions.
  function automatic reg_map_t reg_map(input bit latched);
    reg_map_t m;
    m.status = 3'd0;
    if (latched) begin
      m.ack     = 3'd2;
      m.mask    = 3'd3;
      m.mset    = 3'd4;
      m.mclr    = 3'd5;
      m.has_ack = 1'b1;
    end else begin
      m.ack     = 3'd7;
      m.mask    = 3'd1;
      m.mset    = 3'd2;
      m.mclr    = 3'd3;
      m.has_ack = 1'b0;
    end
    return m;
  endfunction

endpackage

// File: rtl/l2irq_sync.sv
module l2irq_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= '0;
    else        chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= '0;
      else        chain[s] <= chain[s-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/l2irq_capture.sv
module l2irq_capture #(
  parameter int W       = 32,
  parameter bit LATCHED = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] sync_in,
  input  logic         ack_we,
  input  logic [W-1:0] ack_bits,
  output logic [W-1:0] status,
  output logic [W-1:0] rise
);
  if (LATCHED) begin : g_latched
    logic [W-1:0] prev_q;
    logic [W-1:0] stat_q;
    logic [W-1:0] clr_bits;

    assign rise     = sync_in & ~prev_q;
    assign clr_bits = ack_we ? ack_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q <= '0;
        stat_q <= '0;
      end else begin
        prev_q <= sync_in;
        // a fresh edge outranks an acknowledge in the same cycle
        stat_q <= (stat_q & ~clr_bits) | rise;
      end
    end
    assign status = stat_q;
  end else begin : g_level
    logic unused_ack;
    assign unused_ack = ack_we ^ (^ack_bits);
    assign rise       = '0;
    assign status     = sync_in;
  end
endmodule

// File: rtl/l2irq_maskreg.sv
module l2irq_maskreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_we,
  input  logic         clr_we,
  input  logic [W-1:0] bits,
  output logic [W-1:0] mask
);
  logic [W-1:0] mask_q;
  logic [W-1:0] set_v;
  logic [W-1:0] clr_v;

  assign set_v = set_we ? bits : '0;
  assign clr_v = clr_we ? bits : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mask_q <= '1;
    else        mask_q <= (mask_q | set_v) & ~clr_v;
  end

  assign mask = mask_q;
endmodule

// File: rtl/l2irq_ctrl.sv
module l2irq_ctrl
  import l2irq_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit LATCHED     = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_in,
  input  logic               bus_sel,
  input  logic               bus_wr,
  input  logic [WORD_AW-1:0] bus_addr,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  output logic               irq_out
);
  localparam reg_map_t MAP = reg_map(LATCHED);

  logic [NUM_SRC-1:0] sync_w;
  logic [NUM_SRC-1:0] status_q;
  logic [NUM_SRC-1:0] rise_w;
  logic [NUM_SRC-1:0] mask_q;
  logic               wr_en;
  logic               rd_en;
  logic               we_ack;
  logic               we_set;
  logic               we_clr;
  logic               irq_q;

  assign wr_en  = bus_sel & bus_wr;
  assign rd_en  = bus_sel & ~bus_wr;
  assign we_ack = wr_en & MAP.has_ack & (bus_addr == MAP.ack);
  assign we_set = wr_en & (bus_addr == MAP.mset);
  assign we_clr = wr_en & (bus_addr == MAP.mclr);

  l2irq_sync #(.W(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (src_in),
    .q     (sync_w)
  );

  l2irq_capture #(.W(NUM_SRC), .LATCHED(LATCHED)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_w),
    .ack_we   (we_ack),
    .ack_bits (bus_wdata),
    .status   (status_q),
    .rise     (rise_w)
  );

  l2irq_maskreg #(.W(NUM_SRC)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_we (we_set),
    .clr_we (we_clr),
    .bits   (bus_wdata),
    .mask   (mask_q)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      if (bus_addr == MAP.status)    bus_rdata = status_q;
      else if (bus_addr == MAP.mask) bus_rdata = mask_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |(status_q & ~mask_q);
  end

  assign irq_out = irq_q;
endmodule

// File: rtl/l2irq_chk.sv
module l2irq_chk
  import l2irq_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter bit LATCHED = 1'b1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_sel,
  input logic               bus_wr,
  input logic [WORD_AW-1:0] bus_addr,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] mask,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] rise,
  input logic               irq_out
);
  localparam reg_map_t MAP = reg_map(LATCHED);

  logic c_set, c_clr, c_ack;
  assign c_set = bus_sel && bus_wr && (bus_addr == MAP.mset);
  assign c_clr = bus_sel && bus_wr && (bus_addr == MAP.mclr);
  assign c_ack = bus_sel && bus_wr && MAP.has_ack && (bus_addr == MAP.ack);

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    c_set |=> ((mask & $past(bus_wdata)) == $past(bus_wdata))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    c_clr |=> ((mask & $past(bus_wdata)) == '0)); // R4
  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(c_set || c_clr) |=> $stable(mask)); // R9
  AST_IRQ_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|(status & ~mask))); // R5

  if (LATCHED) begin : g_lat
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      c_ack |=> ((status & $past(bus_wdata) & ~$past(rise)) == '0)); // R3
    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !c_ack |=> ((status & $past(status)) == $past(status))); // R6
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|rise) |=> ((status & $past(rise)) == $past(rise))); // R7
  end
endmodule

bind l2irq_ctrl l2irq_chk #(.NUM_SRC(NUM_SRC), .LATCHED(LATCHED)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .mask      (mask_q),
  .status    (status_q),
  .rise      (rise_w),
  .irq_out   (irq_out)
);

// File: tb/sim_l2irq_ctrl.sv
`timescale 1ns/1ps
module sim_l2irq_ctrl;
  localparam int N = 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n;
  logic [N-1:0] src0, src1;
  logic         sel0, sel1, wr;
  logic [2:0]   addr;
  logic [N-1:0] wdata;
  logic [N-1:0] rd0, rd1;
  logic         irq0, irq1;

  int  n_run  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  l2irq_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2), .LATCHED(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .src_in(src0), .bus_sel(sel0), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd0), .irq_out(irq0));

  l2irq_ctrl #(.NUM_SRC(N), .SYNC_STAGES(2), .LATCHED(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .src_in(src1), .bus_sel(sel1), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rd1), .irq_out(irq1));

  task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bwr(input int dev, input logic [2:0] a, input logic [N-1:0] d);
    @(negedge clk);
    sel0 = (dev == 0); sel1 = (dev == 1); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel0 = 1'b0; sel1 = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic brd(input int dev, input logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk);
    sel0 = (dev == 0); sel1 = (dev == 1); wr = 1'b0; addr = a;
    #1;
    d = (dev == 0) ? rd0 : rd1;
    sel0 = 1'b0; sel1 = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] r;
    logic [N-1:0] pat, en;
    rst_n = 1'b0; src0 = '0; src1 = '0; sel0 = 0; sel1 = 0; wr = 0; addr = '0; wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state, both variants
    brd(0, 3'd0, r); chk("R1 status u0", r, '0);
    brd(0, 3'd3, r); chk("R1 mask u0", r, '1);
    brd(1, 3'd0, r); chk("R1 status u1", r, '0);
    brd(1, 3'd1, r); chk("R1 mask u1", r, '1);
    chk("R1 irq u0", {31'd0, irq0}, '0);
    chk("R1 irq u1", {31'd0, irq1}, '0);

    // latched variant: per-source sweep
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] b;
      b = 1 << i;
      @(negedge clk); src0 = b;
      idle(4);
      brd(0, 3'd0, r); chk("R2 edge sets", r, b);
      chk("R5 masked irq low", {31'd0, irq0}, '0);
      @(negedge clk); src0 = '0;
      idle(4);
      brd(0, 3'd0, r); chk("R2 fall keeps", r, b);
      bwr(0, 3'd5, b); idle(1);
      chk("R5 unmasked irq high", {31'd0, irq0}, 1);
      brd(0, 3'd3, r); chk("R4 mask clear", r, ~b);
      bwr(0, 3'd4, b); idle(1);
      chk("R4 mask set drops irq", {31'd0, irq0}, '0);
      brd(0, 3'd0, r); chk("R6 status kept while masked", r, b);
      bwr(0, 3'd5, b); idle(1);
      chk("R6 irq reappears", {31'd0, irq0}, 1);
      bwr(0, 3'd2, ~b);
      brd(0, 3'd0, r); chk("R3 zero bits no effect", r, b);
      bwr(0, 3'd2, b); idle(1);
      brd(0, 3'd0, r); chk("R3 ack clears", r, '0);
      chk("R5 irq low after ack", {31'd0, irq0}, '0);
      bwr(0, 3'd4, b);
    end

    // R4 zero writes leave mask alone
    bwr(0, 3'd5, '0); bwr(0, 3'd4, '0);
    brd(0, 3'd3, r); chk("R4 zero writes", r, '1);

    // multi-source pattern
    pat = 32'hA5C3_0F01; en = 32'h0000_FF00;
    @(negedge clk); src0 = pat;
    idle(4);
    brd(0, 3'd0, r); chk("R2 pattern latched", r, pat);
    bwr(0, 3'd5, en); idle(1);
    chk("R5 pattern irq", {31'd0, irq0}, {31'd0, |(pat & en)});
    brd(0, 3'd3, r); chk("R4 pattern mask", r, ~en);
    bwr(0, 3'd2, en); idle(1);
    brd(0, 3'd0, r); chk("R3 partial ack", r, pat & ~en);
    chk("R5 irq after partial ack", {31'd0, irq0}, {31'd0, |(pat & ~en & en)});

    // R9 unmapped / write-only reads on latched variant
    for (int a = 1; a < 8; a++) begin
      if (a != 3) begin
        brd(0, a[2:0], r); chk("R9 latched unreadable word", r, '0);
      end
    end
    bwr(0, 3'd1, '1); bwr(0, 3'd6, '1); bwr(0, 3'd7, '1);
    brd(0, 3'd3, r); chk("R9 latched mask untouched", r, ~en);
    brd(0, 3'd0, r); chk("R9 latched status untouched", r, pat & ~en);

    // R7 edge and ack in the same cycle
    @(negedge clk); src0 = '0;
    idle(4);
    bwr(0, 3'd2, '1);
    brd(0, 3'd0, r); chk("R3 full ack", r, '0);
    @(negedge clk); src0 = 32'h0000_0008;
    @(negedge clk);
    @(negedge clk);
    sel0 = 1'b1; wr = 1'b1; addr = 3'd2; wdata = 32'h0000_0008;
    @(negedge clk);
    sel0 = 1'b0; wr = 1'b0; wdata = '0;
    brd(0, 3'd0, r); chk("R7 edge wins over ack", r, 32'h0000_0008);
    bwr(0, 3'd2, 32'h0000_0008);
    brd(0, 3'd0, r); chk("R3 later ack clears", r, '0);

    // level variant sweep
    for (int i = 0; i < N; i++) begin
      logic [N-1:0] b;
      b = 1 << i;
      @(negedge clk); src1 = b;
      idle(4);
      brd(1, 3'd0, r); chk("R8 status follows high", r, b);
      chk("R5 level masked irq", {31'd0, irq1}, '0);
      bwr(1, 3'd3, b); idle(1);
      chk("R5 level irq high", {31'd0, irq1}, 1);
      brd(1, 3'd1, r); chk("R4 level mask clear", r, ~b);
      @(negedge clk); src1 = '0;
      idle(4);
      brd(1, 3'd0, r); chk("R8 status follows low", r, '0);
      chk("R8 irq drops with input", {31'd0, irq1}, '0);
      bwr(1, 3'd2, b);
      brd(1, 3'd1, r); chk("R4 level mask set", r, '1);
    end

    // R9 on level variant: no acknowledge word, words 4..7 unmapped
    @(negedge clk); src1 = 32'h8000_0001;
    idle(4);
    bwr(1, 3'd4, '1); bwr(1, 3'd5, '1); bwr(1, 3'd6, '1); bwr(1, 3'd7, '1);
    brd(1, 3'd1, r); chk("R9 level mask untouched", r, '1);
    brd(1, 3'd0, r); chk("R9 level status untouched", r, 32'h8000_0001);
    for (int a = 2; a < 8; a++) begin
      brd(1, a[2:0], r); chk("R9 level unreadable word", r, '0);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule